// File: doc/BRIEF.md
# Memory Key Renewal and Control Sequencer

This block sits on the control side of a scrambled on-chip memory. Software writes a two-bit command word. Bit 0 asks for a fresh scrambling key. Bit 1 asks for the memory to be filled by an initialization engine. The block runs a level request/acknowledge exchange with an external key provider. The provider returns a key, a nonce and a flag saying whether the key came from a provisioned seed. The block then starts the fill engine through a start/done handshake.

While a key request is outstanding, the block closes a gate that the memory bus logic uses to hold off traffic. It keeps a sticky six-bit status word. A lock bit can freeze the command word until reset.

Three inputs end normal operation until reset: escalation, bus integrity fault and init counter fault. Any of them forces the key and nonce outputs back to fixed defaults and shuts the gate for good. The two faults also drive a fatal alert.

The key provider interface uses a held request, not valid/ready. Back-pressure comes only from the provider: `key_req` stays high until a cycle in which `key_ack` is sampled high, and the key, nonce and seed flag must be valid in that cycle.

The fill engine gets a single-cycle `init_start` and answers with a single-cycle `init_done`. A new start is never issued while a previous fill is still running.

Top module: `memkey_seq`

## Requirements
- R1: After reset: `status_q` is 0, `lock_q` is 1, `key_req` and `init_start` are 0, `mem_gate_en` is 1, `fatal_alert` is 0, and `key_o`/`nonce_o` carry the default key and nonce.
- R2: An accepted command write with bit 0 set, when no request is outstanding, does three things in the next cycle: it raises `key_req`, clears status bit 3 (key valid) and drops `mem_gate_en`.
- R3: In the cycle after `key_ack` is sampled high with `key_req` high, all of the following hold:
  - `key_req` is low.
  - `key_o`/`nonce_o` carry the supplied values.
  - Status bit 3 is 1.
  - Status bit 4 (seed valid) equals `seed_valid_in` as sampled.
  - `mem_gate_en` is 1 again.
- R4: A bit-0 command write while `key_req` is high has no effect: one acknowledge ends the request and no second request follows.
- R5: When one write sets bits 0 and 1, the key exchange runs first. `init_start` stays low while `key_req` is high and pulses in the cycle right after `key_req` falls.
- R6: An init request pulses `init_start` for exactly one cycle. Status bit 5 (init done) sets in the cycle after `init_done`. With `ClearDoneOnInit`=1, bit 5 clears in the cycle after a new init request is accepted.
- R7: `lock_q` resets to 1. Writing 0 clears it, and writing 1 leaves it unchanged. While it is 0, command writes are dropped.
- R8: An `escalate` pulse has these effects from the next cycle until reset:
  - Status bit 2 is set.
  - `key_o`/`nonce_o` are forced to the defaults.
  - `mem_gate_en` is 0.
  - Command writes are ignored.
- R9: A `bus_integ_err` or `init_cnt_err` pulse has these effects from the next cycle until reset:
  - Status bit 0 or bit 1 respectively is set.
  - `fatal_alert` is raised.
  - The same terminal blocking as escalation applies.
- R10: Status bit layout: 0 bus integrity error, 1 init counter error, 2 escalated, 3 key valid, 4 seed valid, 5 init done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Command word write strobe |
| ctl_wdata | input | 2 | Command bits: 0 renew key, 1 initialize |
| lock_we | input | 1 | Lock register write strobe |
| lock_wdata | input | 1 | Lock write value (only 0 has effect) |
| lock_q | output | 1 | Lock state, 1 = command writes allowed |
| status_q | output | 6 | Sticky status word |
| key_req | output | 1 | Held key request to provider |
| key_ack | input | 1 | Provider acknowledge, data valid |
| key_in | input | KeyW | Key from provider |
| nonce_in | input | NonceW | Nonce from provider |
| seed_valid_in | input | 1 | Key derived from provisioned seed |
| key_o | output | KeyW | Active scrambling key |
| nonce_o | output | NonceW | Active scrambling nonce |
| init_start | output | 1 | One-cycle start to fill engine |
| init_done | input | 1 | One-cycle completion from fill engine |
| escalate | input | 1 | Escalation request |
| bus_integ_err | input | 1 | Bus integrity fault |
| init_cnt_err | input | 1 | Init counter fault |
| mem_gate_en | output | 1 | 1 = memory traffic may pass |
| fatal_alert | output | 1 | Fatal fault indication |

## Verification
Several wrong internal states show at the ports, each within one or two cycles:
- **Stuck request flag:** `mem_gate_en` stays closed, and later renewals cannot start.
- **Request flag that never rises:** the gate stays open and status bit 3 never clears.
- **Queued init that launches early:** `init_start` appears while `key_req` is still high.
- **Terminal flag that clears:** the gate reopens, or the live key returns on `key_o`, one cycle after the flag drops.

The bench checks each of these one clock after the stimulus edge.

// File: rtl/memkey_pkg.sv
package memkey_pkg;
  localparam int StW        = 6;
  localparam int StBusErr   = 0;
  localparam int StInitErr  = 1;
  localparam int StEsc      = 2;
  localparam int StKeyOk    = 3;
  localparam int StSeedOk   = 4;
  localparam int StInitDone = 5;

  localparam int CmdW      = 2;
  localparam int CmdRenew  = 0;
  localparam int CmdInit   = 1;
endpackage

// File: rtl/memkey_lock.sv
module memkey_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_we,
  input  logic lock_wdata,
  output logic lock_q
);
  // R7: clear-only lock, resets open
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      lock_q <= 1'b1;
    else if (lock_we && !lock_wdata) lock_q <= 1'b0;
  end
endmodule

// File: rtl/memkey_fault.sv
module memkey_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_integ_err,
  input  logic init_cnt_err,
  input  logic escalate,
  output logic bus_err_q,
  output logic init_err_q,
  output logic esc_q,
  output logic term,
  output logic fatal_alert
);
  // R8 R9: sticky terminal flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_err_q  <= 1'b0;
      init_err_q <= 1'b0;
      esc_q      <= 1'b0;
    end else begin
      if (bus_integ_err) bus_err_q  <= 1'b1;
      if (init_cnt_err)  init_err_q <= 1'b1;
      if (escalate)      esc_q      <= 1'b1;
    end
  end

  assign term        = bus_err_q | init_err_q | esc_q;
  assign fatal_alert = bus_err_q | init_err_q;
endmodule

// File: rtl/memkey_keyreq.sv
module memkey_keyreq #(
  parameter int KeyW   = 64,
  parameter int NonceW = 64,
  parameter logic [KeyW-1:0]   DefKey   = '0,
  parameter logic [NonceW-1:0] DefNonce = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              renew_go,
  input  logic              term,
  input  logic              key_ack,
  input  logic [KeyW-1:0]   key_in,
  input  logic [NonceW-1:0] nonce_in,
  input  logic              seed_valid_in,
  output logic              key_req,
  output logic              key_ok,
  output logic              seed_ok,
  output logic [KeyW-1:0]   key_o,
  output logic [NonceW-1:0] nonce_o
);
  logic [KeyW-1:0]   key_r;
  logic [NonceW-1:0] nonce_r;
  logic              take;

  assign take = key_req && key_ack && !term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_req <= 1'b0;
      key_ok  <= 1'b0;
      seed_ok <= 1'b0;
      key_r   <= DefKey;
      nonce_r <= DefNonce;
    end else if (term) begin
      key_req <= 1'b0;
      key_r   <= DefKey;
      nonce_r <= DefNonce;
    end else if (take) begin
      // R3: drop request the cycle after ack, load response
      key_req <= 1'b0;
      key_ok  <= 1'b1;
      seed_ok <= seed_valid_in;
      key_r   <= key_in;
      nonce_r <= nonce_in;
    end else if (renew_go && !key_req) begin
      // R2 R4: start only when idle
      key_req <= 1'b1;
      key_ok  <= 1'b0;
    end
  end

  // R8: defaults visible as soon as a terminal flag is set
  assign key_o   = term ? DefKey   : key_r;
  assign nonce_o = term ? DefNonce : nonce_r;
endmodule

// File: rtl/memkey_initseq.sv
module memkey_initseq #(
  parameter bit ClearDoneOnInit = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_go,
  input  logic key_busy,
  input  logic term,
  input  logic init_done,
  output logic init_start,
  output logic done_q
);
  logic pend_q, busy_q;

  // R5: a queued request waits for the key exchange to finish
  assign init_start = pend_q && !busy_q && !key_busy && !term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (term) begin
        pend_q <= 1'b0;
      end else if (init_go) begin
        pend_q <= 1'b1;
      end else if (init_start) begin
        pend_q <= 1'b0;
      end

      if (init_start)                busy_q <= 1'b1;
      else if (busy_q && init_done)  busy_q <= 1'b0;

      // R6: done flag handling
      if (busy_q && init_done)                 done_q <= 1'b1;
      else if (init_go && ClearDoneOnInit)     done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/memkey_seq.sv
module memkey_seq
  import memkey_pkg::*;
#(
  parameter int KeyW   = 64,
  parameter int NonceW = 64,
  parameter logic [KeyW-1:0]   DefKey   = {(KeyW/8){8'h5A}},
  parameter logic [NonceW-1:0] DefNonce = {(NonceW/8){8'hA5}},
  parameter bit ClearDoneOnInit = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CmdW-1:0]   ctl_wdata,
  input  logic              lock_we,
  input  logic              lock_wdata,
  output logic              lock_q,
  output logic [StW-1:0]    status_q,
  output logic              key_req,
  input  logic              key_ack,
  input  logic [KeyW-1:0]   key_in,
  input  logic [NonceW-1:0] nonce_in,
  input  logic              seed_valid_in,
  output logic [KeyW-1:0]   key_o,
  output logic [NonceW-1:0] nonce_o,
  output logic              init_start,
  input  logic              init_done,
  input  logic              escalate,
  input  logic              bus_integ_err,
  input  logic              init_cnt_err,
  output logic              mem_gate_en,
  output logic              fatal_alert
);
  logic term, bus_err_q, init_err_q, esc_q;
  logic key_ok, seed_ok, done_q;
  logic accept;

  memkey_lock u_lock (
    .clk, .rst_n, .lock_we, .lock_wdata, .lock_q
  );

  memkey_fault u_fault (
    .clk, .rst_n, .bus_integ_err, .init_cnt_err, .escalate,
    .bus_err_q, .init_err_q, .esc_q, .term, .fatal_alert
  );

  // R7 R8: writes accepted only when unlocked and not terminal
  assign accept = ctl_we && lock_q && !term;

  memkey_keyreq #(
    .KeyW(KeyW), .NonceW(NonceW), .DefKey(DefKey), .DefNonce(DefNonce)
  ) u_key (
    .clk, .rst_n,
    .renew_go (accept && ctl_wdata[CmdRenew]),
    .term, .key_ack, .key_in, .nonce_in, .seed_valid_in,
    .key_req, .key_ok, .seed_ok, .key_o, .nonce_o
  );

  memkey_initseq #(.ClearDoneOnInit(ClearDoneOnInit)) u_init (
    .clk, .rst_n,
    .init_go  (accept && ctl_wdata[CmdInit]),
    .key_busy (key_req),
    .term, .init_done, .init_start, .done_q
  );

  // R10: status layout
  always_comb begin
    status_q             = '0;
    status_q[StBusErr]   = bus_err_q;
    status_q[StInitErr]  = init_err_q;
    status_q[StEsc]      = esc_q;
    status_q[StKeyOk]    = key_ok;
    status_q[StSeedOk]   = seed_ok;
    status_q[StInitDone] = done_q;
  end

  // R2 R8: traffic gate
  assign mem_gate_en = !key_req && !term;
endmodule

// File: rtl/memkey_seq_chk.sv
module memkey_seq_chk #(
  parameter int KeyW   = 64,
  parameter int NonceW = 64,
  parameter logic [KeyW-1:0]   DefKey   = '0,
  parameter logic [NonceW-1:0] DefNonce = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_we,
  input logic [1:0]        ctl_wdata,
  input logic              lock_q,
  input logic [5:0]        status_q,
  input logic              key_req,
  input logic              key_ack,
  input logic [KeyW-1:0]   key_o,
  input logic [NonceW-1:0] nonce_o,
  input logic              init_start,
  input logic              bus_integ_err,
  input logic              init_cnt_err,
  input logic              mem_gate_en,
  input logic              fatal_alert
);
  logic term;
  assign term = |status_q[2:0];

  // R2
  renew_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_wdata[0] && lock_q && !key_req && !term |=> key_req && !status_q[3]);

  // R2
  gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_req |-> !mem_gate_en);

  // R3
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_req && key_ack && !term |=> !key_req && status_q[3]);

  // R5
  init_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |-> !key_req);

  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> !init_start);

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |=> !lock_q);

  // R7
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q && !key_req |=> !key_req);

  // R8
  esc_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[2] |-> !mem_gate_en && key_o == DefKey && nonce_o == DefNonce);

  // R8
  esc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[2] |=> status_q[2]);

  // R9
  bus_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_integ_err |=> fatal_alert && status_q[0] && !mem_gate_en);

  // R9
  cnt_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_cnt_err |=> fatal_alert && status_q[1] && !mem_gate_en);

  // R9
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_alert |=> fatal_alert);
endmodule

bind memkey_seq memkey_seq_chk #(
  .KeyW(KeyW), .NonceW(NonceW), .DefKey(DefKey), .DefNonce(DefNonce)
) i_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .lock_q(lock_q), .status_q(status_q), .key_req(key_req), .key_ack(key_ack),
  .key_o(key_o), .nonce_o(nonce_o), .init_start(init_start),
  .bus_integ_err(bus_integ_err), .init_cnt_err(init_cnt_err),
  .mem_gate_en(mem_gate_en), .fatal_alert(fatal_alert)
);

// File: tb/test_memkey_seq.sv
module test_memkey_seq;
  localparam int KW = 8;
  localparam int NW = 8;
  localparam logic [KW-1:0] DK = 8'h3C;
  localparam logic [NW-1:0] DN = 8'hC3;

  logic clk = 1'b0;
  logic rst_n;
  logic ctl_we, lock_we, lock_wdata, key_ack, seed_valid_in;
  logic [1:0] ctl_wdata;
  logic [KW-1:0] key_in, key_o;
  logic [NW-1:0] nonce_in, nonce_o;
  logic lock_q, key_req, init_start, init_done, escalate;
  logic bus_integ_err, init_cnt_err, mem_gate_en, fatal_alert;
  logic [5:0] status_q;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  memkey_seq #(.KeyW(KW), .NonceW(NW), .DefKey(DK), .DefNonce(DN),
               .ClearDoneOnInit(1'b1)) i_memkey_seq (
    .clk, .rst_n, .ctl_we, .ctl_wdata, .lock_we, .lock_wdata, .lock_q,
    .status_q, .key_req, .key_ack, .key_in, .nonce_in, .seed_valid_in,
    .key_o, .nonce_o, .init_start, .init_done, .escalate, .bus_integ_err,
    .init_cnt_err, .mem_gate_en, .fatal_alert
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    ctl_we = 0; ctl_wdata = 0; lock_we = 0; lock_wdata = 0;
    key_ack = 0; key_in = 0; nonce_in = 0; seed_valid_in = 0;
    init_done = 0; escalate = 0; bus_integ_err = 0; init_cnt_err = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [1:0] v);
    ctl_we = 1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 0; ctl_wdata = 0;
  endtask

  task automatic wr_lock(input logic v);
    lock_we = 1; lock_wdata = v;
    @(negedge clk);
    lock_we = 0; lock_wdata = 0;
  endtask

  task automatic give_key(input logic [KW-1:0] k, input logic [NW-1:0] n, input logic s);
    key_ack = 1; key_in = k; nonce_in = n; seed_valid_in = s;
    @(negedge clk);
    key_ack = 0; key_in = 0; nonce_in = 0; seed_valid_in = 0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 status", status_q, 0);
    chk("R1 lock", lock_q, 1);
    chk("R1 key_req", key_req, 0);
    chk("R1 init_start", init_start, 0);
    chk("R1 gate", mem_gate_en, 1);
    chk("R1 fatal", fatal_alert, 0);
    chk("R1 key", key_o, DK);
    chk("R1 nonce", nonce_o, DN);

    // R2 R3 sweep over acknowledge delay and seed flag
    for (int d = 0; d < 6; d++) begin
      logic [KW-1:0] k;
      logic [NW-1:0] n;
      k = 8'(8'h10 + d * 7);
      n = 8'(8'hE0 - d * 3);
      wr_ctl(2'b01);
      chk("R2 req up", key_req, 1);
      chk("R2 key valid cleared", status_q[3], 0);
      chk("R2 gate closed", mem_gate_en, 0);
      repeat (d) @(negedge clk);
      chk("R3 req held", key_req, 1);
      give_key(k, n, d[0]);
      chk("R3 req down", key_req, 0);
      chk("R3 key", key_o, k);
      chk("R3 nonce", nonce_o, n);
      chk("R3 key valid", status_q[3], 1);
      chk("R3 seed valid", status_q[4], d[0]);
      chk("R3 gate open", mem_gate_en, 1);
    end

    // R4 renew while pending is ignored
    wr_ctl(2'b01);
    wr_ctl(2'b01);
    chk("R4 req still up", key_req, 1);
    give_key(8'h77, 8'h88, 1'b0);
    chk("R4 req down", key_req, 0);
    @(negedge clk);
    chk("R4 no second req", key_req, 0);
    chk("R4 key kept", key_o, 8'h77);

    // R5 R6 combined write: key first, then init
    wr_ctl(2'b11);
    chk("R5 req up", key_req, 1);
    chk("R5 no early start", init_start, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 start waits", init_start, 0);
    end
    give_key(8'h21, 8'h43, 1'b1);
    chk("R5 start after key", init_start, 1);
    @(negedge clk);
    chk("R6 start one cycle", init_start, 0);
    chk("R6 done not yet", status_q[5], 0);
    init_done = 1; @(negedge clk); init_done = 0;
    chk("R6 done set", status_q[5], 1);
    wr_ctl(2'b10);
    chk("R6 done cleared on new init", status_q[5], 0);
    chk("R6 init-only start", init_start, 1);
    @(negedge clk);
    init_done = 1; @(negedge clk); init_done = 0;
    chk("R6 done set again", status_q[5], 1);
    chk("R10 status layout", status_q, 6'b111000);

    // R7 lock sweep over lock state and all command values
    for (int lk = 0; lk < 2; lk++) begin
      for (int v = 0; v < 4; v++) begin
        do_reset();
        if (lk == 0) begin
          wr_lock(1'b0);
          chk("R7 lock cleared", lock_q, 0);
          wr_lock(1'b1);
          chk("R7 lock write1 no effect", lock_q, 0);
        end
        wr_ctl(2'(v));
        chk("R7 req per lock", key_req, 32'(lk & v));
        chk("R7 start per lock", init_start, 32'(lk & (v >> 1) & ~v & 1));
      end
    end

    // R8 escalation
    do_reset();
    wr_ctl(2'b01);
    give_key(8'h5A, 8'hA5, 1'b1);
    chk("R8 live key", key_o, 8'h5A);
    escalate = 1; @(negedge clk); escalate = 0;
    chk("R8 escalated bit", status_q[2], 1);
    chk("R8 key default", key_o, DK);
    chk("R8 nonce default", nonce_o, DN);
    chk("R8 gate closed", mem_gate_en, 0);
    chk("R8 no fatal", fatal_alert, 0);
    wr_ctl(2'b11);
    chk("R8 write ignored req", key_req, 0);
    chk("R8 write ignored start", init_start, 0);
    repeat (3) @(negedge clk);
    chk("R8 sticky", status_q[2], 1);
    chk("R10 escalated layout", status_q, 6'b011100);

    // R9 bus integrity fault
    do_reset();
    bus_integ_err = 1; @(negedge clk); bus_integ_err = 0;
    chk("R9 bus err status", status_q, 6'b000001);
    chk("R9 bus fatal", fatal_alert, 1);
    chk("R9 bus gate", mem_gate_en, 0);
    wr_ctl(2'b01);
    chk("R9 bus blocks renew", key_req, 0);
    chk("R9 bus sticky", fatal_alert, 1);

    // R9 init counter fault
    do_reset();
    init_cnt_err = 1; @(negedge clk); init_cnt_err = 0;
    chk("R9 cnt err status", status_q, 6'b000010);
    chk("R9 cnt fatal", fatal_alert, 1);
    chk("R9 cnt key default", key_o, DK);
    chk("R9 cnt gate", mem_gate_en, 0);

    summary();
    $finish;
  end
endmodule